// File: doc/BRIEF.md
# Hertz-Programmed Sine Synthesizer

This block is a direct digital synthesis sine source for a 50 MHz sample clock. The requested frequency arrives as an 18-bit unsigned number in hertz, with a control that scales it by sixteen. The block turns that number into a 32-bit phase step and adds the step to a phase register on every clock. It reads the top byte of the phase from a 256-entry table of unsigned 10-bit sine codes, and it registers the result.

The sample goes straight to a 10-bit video-style DAC, which takes one new code on every clock. The DAC's blanking and sync controls are held high, so the DAC works as a plain converter. A DAC cannot stall, so the sample path has no valid/ready handshake and no back-pressure. The frequency inputs are plain control pins. Any change on them reaches the output phase after a short, fixed latency, and the phase does not jump when the frequency changes.

Top module: `hz_sine_synth`

## Requirements
- R1: A synchronous reset clears the phase register and the step pipeline. While reset is high, and on the first sample after it is released, the output code is 512.
- R2: The effective frequency is freq_hz when freq_x16 is 0. It is freq_hz shifted left by 4 bits (times 16) when freq_x16 is 1.
- R3: The phase step is floor((f_eff * 1441151881 + 2^23) / 2^24), truncated to 32 bits. This approximates round(f_eff * 2^32 / 50e6). For example, 128 Hz gives a step of 10995.
- R4: The frequency inputs are registered on one clock edge. The step derived from them is registered on the next edge, and it is first added to the phase on the edge after that.
- R5: On every clock, the phase register adds the current step modulo 2^32. It never saturates, and it is never reloaded when the frequency changes, so the phase stays continuous.
- R6: Phase bits 31..24 address the table, and entry k is trunc(512 + 511*sin(2*pi*k/256)). This gives 512 at k=0, 1023 at k=64 and 1 at k=192. The code is registered, so it appears one clock after the phase value that selected it.
- R7: When the effective frequency is zero, the phase stops once the pipeline drains, and the output holds its last code.
- R8: When f_eff is at or below 390625 Hz, each output period passes through at least 32 changes of code.
- R9: The output dac_blank_n and dac_sync_n are driven high at all times.
- R10: The number of clocks between successive upward crossings of code 512 matches 50e6 / f_eff to within two clocks when summed over the measured periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz sample clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_hz | input | 18 | Requested frequency in hertz, unsigned |
| freq_x16 | input | 1 | Scale the requested frequency by 16 when high |
| dac_sample | output | 10 | Registered unsigned sine code, centred on 512 |
| dac_blank_n | output | 1 | DAC blanking control, held high |
| dac_sync_n | output | 1 | DAC sync control, held high |

## Verification
The hardest case to reach from the ports is a phase that stays continuous while the frequency is reprogrammed in the middle of a wrap. The step is buried two registers deep, so it cannot be seen directly. The bench runs at the largest scaled frequency, where the 32-bit phase wraps every dozen clocks, and then switches to other settings without a reset. It compares every sample against its own cycle model, which is built from the latency and step rules, so one wrong step or one reloaded phase shows up as a mismatched code. Slow sweeps that visit all 256 addresses check the table, including the exact peak, trough and mid codes.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // pi scaled by 2^30 for the elaboration-time sine evaluation
  localparam longint PI_Q30  = 64'sd3373259426;
  localparam longint ONE_Q30 = 64'sd1073741824;

  // Unsigned sine code for table index k, with 2^aw entries and sw-bit codes.
  // The result truncates toward zero: floor above mid-scale, ceiling of the
  // magnitude below it.
  function automatic logic [31:0] sine_code(longint k, longint aw, longint sw);
    longint n, quarter, q, x, x2, term, s, prod, mag, amp, mid;
    bit     neg;
    n       = longint'(1) << aw;
    quarter = n / 4;
    amp     = (longint'(1) << (sw - 1)) - 1;
    mid     = longint'(1) << (sw - 1);
    k       = k % n;
    neg     = (k > n / 2);
    q       = neg ? k - n / 2 : k;
    if (q > quarter) q = n / 2 - q;
    if (q == 0) begin
      mag = 0;
    end else if (q == quarter) begin
      mag = amp;
    end else begin
      x  = (PI_Q30 * q) / (n / 2);
      x2 = (x * x) >>> 30;
      term = x;
      s    = x;
      for (longint i = 1; i <= 10; i++) begin
        term = -((term * x2) >>> 30) / ((2 * i) * (2 * i + 1));
        s    = s + term;
      end
      prod = amp * s;
      mag  = neg ? (prod + ONE_Q30 - 1) >>> 30 : prod >>> 30;
    end
    return 32'(neg ? mid - mag : mid + mag);
  endfunction

endpackage

// File: rtl/dds_tune.sv
module dds_tune #(
  parameter int FREQ_W      = 18,
  parameter int SCALE_SHIFT = 4,
  parameter int PHASE_W     = 32,
  parameter int K_FRAC      = 24,
  parameter int CLK_HZ      = 50_000_000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FREQ_W-1:0]  freq_hz,
  input  logic               freq_x16,
  output logic [PHASE_W-1:0] step
);
  localparam int FEFF_W = FREQ_W + SCALE_SHIFT;
  localparam int PROD_W = PHASE_W + K_FRAC;
  // steps per hertz in fixed point: round(2^(PHASE_W+K_FRAC) / CLK_HZ)
  localparam logic [63:0] K_WIDE =
    ((64'd1 << PROD_W) + 64'(CLK_HZ / 2)) / 64'(CLK_HZ);
  localparam logic [PROD_W-1:0] K_CONST = K_WIDE[PROD_W-1:0];
  localparam logic [PROD_W-1:0] HALF    = PROD_W'(1) << (K_FRAC - 1);

  logic [FEFF_W-1:0] feff_q;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] rounded;

  always_comb begin
    prod    = PROD_W'(feff_q) * K_CONST;
    rounded = prod + HALF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      feff_q <= '0;
      step   <= '0;
    end else begin
      feff_q <= freq_x16 ? {freq_hz, {SCALE_SHIFT{1'b0}}} : FEFF_W'(freq_hz);
      step   <= PHASE_W'(rounded >> K_FRAC);
    end
  end

  // R3: a zero request two edges back must leave a zero step
  a_r3_zero_freq_zero_step: assert property (@(posedge clk) disable iff (rst)
    $past(freq_hz == '0, 2) |-> step == '0);

endmodule

// File: rtl/dds_phase.sv
module dds_phase #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] step,
  output logic [ADDR_W-1:0]  addr
);
  logic [PHASE_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + step;
  end

  assign addr = acc[PHASE_W-1 -: ADDR_W];

  // R1: phase starts from zero after reset
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> acc == '0);

  // R7: a zero step freezes the phase
  a_r7_zero_step_holds: assert property (@(posedge clk) disable iff (rst)
    (step == '0) |=> $stable(acc));

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  output logic [SAMPLE_W-1:0] sample
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int QUARTER = DEPTH / 4;
  localparam logic [SAMPLE_W-1:0] MID  = SAMPLE_W'(1) << (SAMPLE_W - 1);
  localparam logic [SAMPLE_W-1:0] PEAK = {SAMPLE_W{1'b1}};

  logic [SAMPLE_W-1:0] table_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam logic [31:0] CODE =
      dds_pkg::sine_code(longint'(i), longint'(ADDR_W), longint'(SAMPLE_W));
    assign table_w[i] = CODE[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) sample <= MID;
    else     sample <= table_w[addr];
  end

  // R6: peak and mid codes land one clock after their addresses
  a_r6_peak_code: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(QUARTER)) |=> sample == PEAK);
  a_r6_mid_code: assert property (@(posedge clk) disable iff (rst)
    (addr == '0) |=> sample == MID);

endmodule

// File: rtl/hz_sine_synth.sv
module hz_sine_synth #(
  parameter int FREQ_W      = 18,
  parameter int SCALE_SHIFT = 4,
  parameter int PHASE_W     = 32,
  parameter int ADDR_W      = 8,
  parameter int SAMPLE_W    = 10,
  parameter int K_FRAC      = 24,
  parameter int CLK_HZ      = 50_000_000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FREQ_W-1:0]   freq_hz,
  input  logic                freq_x16,
  output logic [SAMPLE_W-1:0] dac_sample,
  output logic                dac_blank_n,
  output logic                dac_sync_n
);
  logic [PHASE_W-1:0] step;
  logic [ADDR_W-1:0]  addr;

  dds_tune #(
    .FREQ_W(FREQ_W), .SCALE_SHIFT(SCALE_SHIFT), .PHASE_W(PHASE_W),
    .K_FRAC(K_FRAC), .CLK_HZ(CLK_HZ)
  ) u_tune (
    .clk(clk), .rst(rst), .freq_hz(freq_hz), .freq_x16(freq_x16), .step(step)
  );

  dds_phase #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_phase (
    .clk(clk), .rst(rst), .step(step), .addr(addr)
  );

  dds_sine_rom #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_rom (
    .clk(clk), .rst(rst), .addr(addr), .sample(dac_sample)
  );

  assign dac_blank_n = 1'b1;
  assign dac_sync_n  = 1'b1;

endmodule

// File: tb/hz_sine_synth_tb.sv
module hz_sine_synth_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] freq_hz = '0;
  logic        freq_x16 = 1'b0;
  logic [9:0]  dac_sample;
  logic        dac_blank_n, dac_sync_n;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  hz_sine_synth u_dut (
    .clk(clk), .rst(rst), .freq_hz(freq_hz), .freq_x16(freq_x16),
    .dac_sample(dac_sample), .dac_blank_n(dac_blank_n), .dac_sync_n(dac_sync_n)
  );

  // expected table entry from real arithmetic (R6)
  function automatic int exp_code(int k);
    real v;
    v = 512.0 + 511.0 * $sin(2.0 * 3.14159265358979 * k / 256.0);
    return $rtoi(v);
  endfunction

  // step rule from R2/R3
  function automatic longint exp_step(longint feff);
    return ((feff * 64'd1441151881 + 64'd8388608) >> 24) & 64'hFFFF_FFFF;
  endfunction

  // cycle model from R1, R4, R5, R6
  longint m_feff, m_step, m_acc;
  int     m_smp;
  always @(posedge clk) begin
    if (rst) begin
      m_feff <= 0; m_step <= 0; m_acc <= 0; m_smp <= 512;
    end else begin
      m_feff <= freq_x16 ? longint'(freq_hz) * 16 : longint'(freq_hz);
      m_step <= exp_step(m_feff);
      m_acc  <= (m_acc + m_step) & 64'hFFFF_FFFF;
      m_smp  <= exp_code(int'((m_acc >> 24) & 255));
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_freq(int f, bit x16);
    @(negedge clk);
    freq_hz  = 18'(f);
    freq_x16 = x16;
  endtask

  task automatic compare_run(int cycles, string req, string what);
    int mism = 0;
    int a = 0, e = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (int'(dac_sample) != m_smp) begin
        if (mism == 0) begin a = int'(dac_sample); e = m_smp; end
        mism++;
      end
    end
    check(mism == 0, req, what, a, e);
  endtask

  task automatic measure(int periods, output int cyc);
    int prev, cur, cnt;
    bit started = 0;
    int seen = 0;
    cur = int'(dac_sample);
    cnt = 0;
    while (seen < periods) begin
      @(negedge clk);
      prev = cur;
      cur = int'(dac_sample);
      if (started) cnt++;
      if (prev < 512 && cur >= 512) begin
        if (started) seen++;
        started = 1;
      end
    end
    cyc = cnt;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    freq_hz = 18'd1000;
    freq_x16 = 1'b0;
    repeat (4) @(negedge clk);
    check(dac_sample == 10'd512, "R1", "code in reset", dac_sample, 512);
    check(dac_blank_n && dac_sync_n, "R9", "blank/sync high in reset",
          {dac_blank_n, dac_sync_n}, 3);
    rst = 1'b0;
    @(negedge clk);
    check(dac_sample == 10'd512, "R1", "first code after reset", dac_sample, 512);
  endtask

  task automatic t_example_128;
    set_freq(128, 1'b0);
    compare_run(3500, "R3", "128 Hz stream");
    set_freq(128, 1'b1);
    compare_run(1500, "R2", "128 Hz scaled stream");
  endtask

  task automatic t_period;
    int c;
    set_freq(100000, 1'b0);
    repeat (20) @(negedge clk);
    measure(8, c);
    check(c >= 3998 && c <= 4002, "R10", "8 periods at 100 kHz", c, 4000);
    set_freq(6250, 1'b1);
    repeat (20) @(negedge clk);
    measure(8, c);
    check(c >= 3998 && c <= 4002, "R2", "8 periods at 6250x16", c, 4000);
    set_freq(6250, 1'b0);
    repeat (20) @(negedge clk);
    measure(1, c);
    check(c >= 7998 && c <= 8002, "R10", "1 period at 6250 Hz", c, 8000);
  endtask

  task automatic t_latency;
    // change mid-stream; model tracks exact edge of the new step (R4)
    set_freq(50000, 1'b0);
    compare_run(300, "R4", "step latency after change");
    set_freq(3, 1'b1);
    compare_run(300, "R4", "step latency after second change");
  endtask

  task automatic t_table_and_density;
    int changes = 0;
    int prev;
    set_freq(20000, 1'b0);
    compare_run(2600, "R6", "full table sweep");
    prev = int'(dac_sample);
    for (int i = 0; i < 2500; i++) begin
      @(negedge clk);
      if (int'(dac_sample) != prev) changes++;
      prev = int'(dac_sample);
    end
    check(changes >= 32, "R8", "code changes per period", changes, 32);
  endtask

  task automatic t_wrap;
    set_freq(262143, 1'b1);
    compare_run(3000, "R5", "max frequency wrap");
    set_freq(99999, 1'b0);
    compare_run(1000, "R5", "continuous phase after change");
  endtask

  task automatic t_zero;
    int held;
    int moved = 0;
    set_freq(0, 1'b1);
    repeat (5) @(negedge clk);
    held = int'(dac_sample);
    check(held == m_smp, "R7", "held code", held, m_smp);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (int'(dac_sample) != held) moved++;
    end
    check(moved == 0, "R7", "code changes while zero", moved, 0);
    check(dac_blank_n && dac_sync_n, "R9", "blank/sync high in run",
          {dac_blank_n, dac_sync_n}, 3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_example_128();
    t_period();
    t_latency();
    t_table_and_density();
    t_wrap();
    t_zero();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule